// File: doc/BRIEF.md
# Indexed Clock-Parameter Register Bank

This block stores the programming words for a clock synthesizer behind a single 8-bit data port and a 4-bit index register. The host loads an index, then streams bytes through the data port. A byte pointer inside the block steps from the low byte to the high byte of the selected entry. After the last byte of an entry it returns to the low byte and advances the index, so the host can program or dump several entries in one run of accesses.

Seven entries, at indices 0x0 to 0x6, are 16 bits wide. One entry, at index 0xE, is 8 bits wide, and it advances the index after a single byte. The remaining indices are holes: writes to them are dropped, reads return zero, and the pointer still steps over them as if they were 16-bit entries. A written low byte waits in a shadow register. The entry changes only when the high byte arrives, so a half-written word never reaches the synthesizer.

The entry chosen by `act_sel` is presented on `act_value`. Whenever that entry is committed, the block pulses `upd_stb` for one cycle so the synthesizer can reload.

The write channel and the read-request channel use valid/ready handshakes. A transfer happens in a cycle where both are high.
- The write channel is never stalled, except in a cycle where the index is being loaded.
- The read-response channel holds `rd_rsp_valid` and `rd_rsp_data` until `rd_rsp_ready` is seen.
- While a response is held, no new read request is taken.

Top module: `pllbank_regs`

## Requirements
- R1: After reset, the index is 0x0, the pointer is on the low byte, every entry is zero, `act_value` is 0x0000, and both `upd_stb` and `rd_rsp_valid` are low.
- R2: An index load writes `idx_din` into the index and returns the pointer to the low byte. `idx_q` shows the new index in the following cycle. The same physical register serves both writing and reading of entries.
- R3: For a 16-bit entry (index 0x0 to 0x6), the first data access after an index load touches bits [7:0] and the second touches bits [15:8]. This holds for both reads and writes. After the second access, the index increments.
- R4: For the 8-bit entry at index 0xE, the index increments after one data access, and the next access is a low-byte access.
- R5: Indices 0x7 to 0xD and 0xF are unmapped. Writes to them change no stored entry, reads return 0x00, and the pointer steps over them in two accesses.
- R6: The index wraps from 0xF to 0x0 when it increments.
- R7: A low-byte write to a 16-bit entry leaves the stored entry unchanged. The full word {high, low} is committed in one step when the high byte is written, and `act_value` then shows it. For index 0xE, `act_value` shows the byte zero-extended.
- R8: `upd_stb` goes high for exactly one cycle, in the cycle after a commit, when the committed index equals `act_sel`. It stays low for a commit to any other index.
- R9: While `rd_rsp_valid` is high and `rd_rsp_ready` is low, the response data stays stable, `rd_req_ready` is low, and the index and pointer do not move on a read request.
- R10: An index load takes precedence over both data channels: `wr_ready` and `rd_req_ready` are low in that cycle. A data write takes precedence over a read request made in the same cycle, and `rd_req_ready` is low then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Load the index register |
| idx_din | input | 4 | New index value |
| idx_q | output | 4 | Current index readback |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte accepted |
| wr_data | input | 8 | Write byte |
| rd_req_valid | input | 1 | Read request offered |
| rd_req_ready | output | 1 | Read request accepted |
| rd_rsp_valid | output | 1 | Read response present |
| rd_rsp_ready | input | 1 | Host takes the read response |
| rd_rsp_data | output | 8 | Read response byte |
| act_sel | input | 4 | Index of the entry driving the synthesizer |
| act_value | output | 16 | Committed value of the selected entry |
| upd_stb | output | 1 | One-cycle pulse when the selected entry is committed |

## Verification
A vector table runs write-then-readback sequences over three kinds of index: a 16-bit entry, the 8-bit entry at 0xE, and unmapped holes. These sequences separate correct byte ordering and entry width from a pointer that always steps in pairs or never steps. A run that crosses 0xF shows whether the index wraps. Directed cases then do the following:
- They write only the low byte with the selected entry active, which tells a shadowed commit from an early partial update.
- They commit an unselected entry, to confirm the strobe stays quiet.
- They stall the response channel, which shows whether a blocked read still moves the pointer.
- They collide an index load or a write with other traffic in the same cycle, to confirm the stated order of precedence.

// File: rtl/pllbank_pkg.sv
package pllbank_pkg;
  localparam int IDX_W      = 4;
  localparam int DATA_W     = 8;
  localparam int NUM_WIDE   = 7;
  localparam int NARROW_IDX = 14;
  localparam int WORD_W     = 2 * DATA_W;
endpackage

// File: rtl/pllbank_ptr.sv
module pllbank_ptr #(
  parameter int IDX_W      = pllbank_pkg::IDX_W,
  parameter int NARROW_IDX = pllbank_pkg::NARROW_IDX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_we,
  input  logic [IDX_W-1:0] idx_din,
  input  logic             acc,
  output logic [IDX_W-1:0] idx_q,
  output logic             byte_hi_q
);
  localparam logic [IDX_W-1:0] NARROW = IDX_W'(NARROW_IDX);
  localparam logic [IDX_W-1:0] TOP    = {IDX_W{1'b1}};

  logic on_narrow, last_byte;
  assign on_narrow = (idx_q == NARROW);
  assign last_byte = on_narrow || byte_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      byte_hi_q <= 1'b0;
    end else if (idx_we) begin
      idx_q     <= idx_din;
      byte_hi_q <= 1'b0;
    end else if (acc) begin
      if (last_byte) begin
        idx_q     <= idx_q + 1'b1;
        byte_hi_q <= 1'b0;
      end else begin
        byte_hi_q <= 1'b1;
      end
    end
  end

  // R2: index load lands and rewinds the pointer
  p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> (idx_q == $past(idx_din)) && !byte_hi_q);

  // R3: low-byte access of a wide or unmapped entry keeps the index
  p_low_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !idx_we && !byte_hi_q && !on_narrow) |=> byte_hi_q && $stable(idx_q));

  // R3: high-byte access advances the index
  p_high_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !idx_we && byte_hi_q && idx_q != TOP) |=>
      !byte_hi_q && (idx_q == $past(idx_q) + 1'b1));

  // R4: the narrow entry advances after one access
  p_narrow_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !idx_we && on_narrow) |=> !byte_hi_q && (idx_q == NARROW + 1'b1));

  // R6: wrap from the top index
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !idx_we && byte_hi_q && idx_q == TOP) |=> (idx_q == '0) && !byte_hi_q);
endmodule

// File: rtl/pllbank_store.sv
module pllbank_store #(
  parameter int IDX_W      = pllbank_pkg::IDX_W,
  parameter int DATA_W     = pllbank_pkg::DATA_W,
  parameter int NUM_WIDE   = pllbank_pkg::NUM_WIDE,
  parameter int NARROW_IDX = pllbank_pkg::NARROW_IDX
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    idx,
  input  logic                byte_hi,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [IDX_W-1:0]    act_sel,
  output logic [DATA_W-1:0]   rd_byte,
  output logic [2*DATA_W-1:0] act_value,
  output logic                upd_stb
);
  localparam int WORD_W = 2 * DATA_W;
  localparam logic [IDX_W-1:0] NARROW   = IDX_W'(NARROW_IDX);
  localparam logic [IDX_W-1:0] WIDE_LIM = IDX_W'(NUM_WIDE);

  logic [WORD_W-1:0] wide_q [NUM_WIDE];
  logic [DATA_W-1:0] narrow_q;
  logic [DATA_W-1:0] shadow_q;

  logic hit_wide, hit_narrow, commit_wide, commit_narrow, commit_any;
  assign hit_wide      = (idx < WIDE_LIM);
  assign hit_narrow    = (idx == NARROW);
  assign commit_wide   = wr_en && byte_hi && hit_wide;
  assign commit_narrow = wr_en && hit_narrow;
  assign commit_any    = commit_wide || commit_narrow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (wr_en && !byte_hi && hit_wide) begin
      shadow_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_WIDE; k++) wide_q[k] <= '0;
      narrow_q <= '0;
    end else begin
      for (int k = 0; k < NUM_WIDE; k++) begin
        if (commit_wide && idx == IDX_W'(k)) wide_q[k] <= {wdata, shadow_q};
      end
      if (commit_narrow) narrow_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) upd_stb <= 1'b0;
    else        upd_stb <= commit_any && (idx == act_sel);
  end

  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < NUM_WIDE; k++) begin
      if (idx == IDX_W'(k))
        rd_byte = byte_hi ? wide_q[k][WORD_W-1:DATA_W] : wide_q[k][DATA_W-1:0];
    end
    if (hit_narrow) rd_byte = narrow_q;
  end

  always_comb begin
    act_value = '0;
    for (int k = 0; k < NUM_WIDE; k++) begin
      if (act_sel == IDX_W'(k)) act_value = wide_q[k];
    end
    if (act_sel == NARROW) act_value = {{DATA_W{1'b0}}, narrow_q};
  end

  // R7: a wide entry changes only on its high-byte write
  for (genvar g = 0; g < NUM_WIDE; g++) begin : g_ent_chk
    p_entry_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && byte_hi && idx == IDX_W'(g)) |=> $stable(wide_q[g]));
  end

  // R5: the narrow entry is untouched by writes to other indices
  p_narrow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit_narrow) |=> $stable(narrow_q));

  // R8: the strobe is a single-cycle pulse
  p_upd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);

  // R8: no strobe without a commit
  p_upd_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_any |=> !upd_stb);
endmodule

// File: rtl/pllbank_rsp.sv
module pllbank_rsp #(
  parameter int DATA_W = pllbank_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] rd_byte,
  input  logic              rsp_ready,
  output logic              slot_free,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  assign slot_free = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_byte;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9: a stalled response holds its data
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));
endmodule

// File: rtl/pllbank_regs.sv
module pllbank_regs #(
  parameter int IDX_W      = pllbank_pkg::IDX_W,
  parameter int DATA_W     = pllbank_pkg::DATA_W,
  parameter int NUM_WIDE   = pllbank_pkg::NUM_WIDE,
  parameter int NARROW_IDX = pllbank_pkg::NARROW_IDX
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idx_we,
  input  logic [IDX_W-1:0]    idx_din,
  output logic [IDX_W-1:0]    idx_q,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_req_valid,
  output logic                rd_req_ready,
  output logic                rd_rsp_valid,
  input  logic                rd_rsp_ready,
  output logic [DATA_W-1:0]   rd_rsp_data,
  input  logic [IDX_W-1:0]    act_sel,
  output logic [2*DATA_W-1:0] act_value,
  output logic                upd_stb
);
  logic byte_hi, slot_free, wr_fire, rd_fire;
  logic [DATA_W-1:0] rd_byte;

  assign wr_ready     = !idx_we;
  assign rd_req_ready = slot_free && !idx_we && !wr_valid;
  assign wr_fire      = wr_valid && wr_ready;
  assign rd_fire      = rd_req_valid && rd_req_ready;

  pllbank_ptr #(.IDX_W(IDX_W), .NARROW_IDX(NARROW_IDX)) u_ptr (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_din(idx_din),
    .acc(wr_fire || rd_fire), .idx_q(idx_q), .byte_hi_q(byte_hi)
  );

  pllbank_store #(.IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_WIDE(NUM_WIDE),
                  .NARROW_IDX(NARROW_IDX)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .idx(idx_q), .byte_hi(byte_hi),
    .wdata(wr_data), .act_sel(act_sel), .rd_byte(rd_byte),
    .act_value(act_value), .upd_stb(upd_stb)
  );

  pllbank_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .rd_byte(rd_byte),
    .rsp_ready(rd_rsp_ready), .slot_free(slot_free),
    .rsp_valid(rd_rsp_valid), .rsp_data(rd_rsp_data)
  );

  // R10: an index load blocks both data channels
  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |-> !wr_ready && !rd_req_ready);

  // R10: a write blocks a same-cycle read
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rd_req_ready);

  // R9: a stalled response blocks a new read
  p_stall_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid && !rd_rsp_ready) |-> !rd_req_ready);
endmodule

// File: tb/pllbank_regs_tb.sv
module pllbank_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 30;
  localparam logic [1:0] OP_IDX = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

  // {op, data, expected index after op, expected read byte}
  localparam logic [21:0] VEC [NV] = '{
    {OP_IDX, 8'h03, 4'h3, 8'h00},  // R2
    {OP_WR,  8'h34, 4'h3, 8'h00},  // R3 low
    {OP_WR,  8'h12, 4'h4, 8'h00},  // R3 high, advance
    {OP_IDX, 8'h03, 4'h3, 8'h00},
    {OP_RD,  8'h00, 4'h3, 8'h34},  // R3 read low
    {OP_RD,  8'h00, 4'h4, 8'h12},  // R3 read high
    {OP_IDX, 8'h0E, 4'hE, 8'h00},
    {OP_WR,  8'hA5, 4'hF, 8'h00},  // R4
    {OP_IDX, 8'h0E, 4'hE, 8'h00},
    {OP_RD,  8'h00, 4'hF, 8'hA5},  // R4
    {OP_WR,  8'h77, 4'hF, 8'h00},  // R5 unmapped low
    {OP_WR,  8'h66, 4'h0, 8'h00},  // R6 wrap
    {OP_IDX, 8'h0F, 4'hF, 8'h00},
    {OP_RD,  8'h00, 4'hF, 8'h00},  // R5 zero
    {OP_RD,  8'h00, 4'h0, 8'h00},  // R6
    {OP_IDX, 8'h06, 4'h6, 8'h00},
    {OP_WR,  8'hCD, 4'h6, 8'h00},
    {OP_WR,  8'hAB, 4'h7, 8'h00},
    {OP_WR,  8'h11, 4'h7, 8'h00},  // R5
    {OP_WR,  8'h22, 4'h8, 8'h00},
    {OP_IDX, 8'h06, 4'h6, 8'h00},
    {OP_RD,  8'h00, 4'h6, 8'hCD},
    {OP_RD,  8'h00, 4'h7, 8'hAB},
    {OP_RD,  8'h00, 4'h7, 8'h00},  // R5
    {OP_RD,  8'h00, 4'h8, 8'h00},
    {OP_IDX, 8'h0D, 4'hD, 8'h00},
    {OP_WR,  8'h44, 4'hD, 8'h00},
    {OP_WR,  8'h55, 4'hE, 8'h00},
    {OP_RD,  8'h00, 4'hF, 8'hA5},  // R4 narrow unchanged by hole
    {OP_RD,  8'h00, 4'hF, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic idx_we = 1'b0; logic [3:0] idx_din = '0; logic [3:0] idx_q;
  logic wr_valid = 1'b0, wr_ready; logic [7:0] wr_data = '0;
  logic rd_req_valid = 1'b0, rd_req_ready, rd_rsp_valid, rd_rsp_ready = 1'b1;
  logic [7:0] rd_rsp_data;
  logic [3:0] act_sel = '0; logic [15:0] act_value; logic upd_stb;

  int n_chk = 0, n_fail = 0;
  logic [7:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  pllbank_regs u_dut (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_din(idx_din), .idx_q(idx_q),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .act_sel(act_sel), .act_value(act_value),
    .upd_stb(upd_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_idx(input logic [3:0] d);
    @(negedge clk); idx_we = 1'b1; idx_din = d;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic do_rd(output logic [7:0] d);
    @(negedge clk); rd_req_valid = 1'b1;
    @(negedge clk); rd_req_valid = 1'b0;
    chk(rd_rsp_valid, "R3 rsp_valid", int'(rd_rsp_valid), 1);
    d = rd_rsp_data;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(idx_q == 4'h0, "R1 idx", int'(idx_q), 0);
    chk(!rd_rsp_valid && !upd_stb, "R1 valid/strobe", int'({rd_rsp_valid, upd_stb}), 0);
    chk(act_value == 16'h0, "R1 act_value", int'(act_value), 0);

    act_sel = 4'h9;  // hole: no strobe during table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [7:0] d; logic [3:0] ei; logic [7:0] er;
      {op, d, ei, er} = VEC[i];
      case (op)
        OP_IDX: do_idx(d[3:0]);
        OP_WR:  do_wr(d);
        default: begin
          do_rd(got);
          chk(got == er, $sformatf("R3/R4/R5 vec %0d read", i), int'(got), int'(er));
        end
      endcase
      chk(idx_q == ei, $sformatf("R2/R3/R6 vec %0d index", i), int'(idx_q), int'(ei));
    end

    // R7 / R8: selected entry, low byte alone must not commit
    act_sel = 4'h2;
    do_idx(4'h2);
    do_wr(8'h55);
    chk(act_value == 16'h0000, "R7 partial", int'(act_value), 16'h0000);
    chk(!upd_stb, "R8 no strobe on low byte", int'(upd_stb), 0);
    do_wr(8'hAA);
    chk(act_value == 16'hAA55, "R7 commit", int'(act_value), 16'hAA55);
    chk(upd_stb, "R8 strobe", int'(upd_stb), 1);
    @(negedge clk);
    chk(!upd_stb, "R8 strobe one cycle", int'(upd_stb), 0);

    // R8: unselected commit
    do_idx(4'h5);
    do_wr(8'h01);
    do_wr(8'h02);
    chk(!upd_stb, "R8 unselected", int'(upd_stb), 0);

    // R8 / R7: narrow entry selected
    act_sel = 4'hE;
    do_idx(4'hE);
    do_wr(8'h3C);
    chk(upd_stb, "R8 narrow strobe", int'(upd_stb), 1);
    chk(act_value == 16'h003C, "R7 narrow value", int'(act_value), 16'h003C);

    // R9: stalled response
    rd_rsp_ready = 1'b0;
    do_idx(4'h3);
    @(negedge clk); rd_req_valid = 1'b1;
    @(negedge clk);
    chk(rd_rsp_valid && rd_rsp_data == 8'h34, "R9 first rsp", int'(rd_rsp_data), 8'h34);
    chk(!rd_req_ready, "R9 req blocked", int'(rd_req_ready), 0);
    @(negedge clk); rd_req_valid = 1'b0;
    chk(rd_rsp_data == 8'h34, "R9 data held", int'(rd_rsp_data), 8'h34);
    chk(idx_q == 4'h3, "R9 index held", int'(idx_q), 3);
    rd_rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rd_rsp_valid, "R9 drained", int'(rd_rsp_valid), 0);
    do_rd(got);
    chk(got == 8'h12, "R9 pointer held at high byte", int'(got), 8'h12);
    chk(idx_q == 4'h4, "R9 index after", int'(idx_q), 4);

    // R10: write beats read in the same cycle
    act_sel = 4'h0;
    do_idx(4'h2);
    @(negedge clk); wr_valid = 1'b1; wr_data = 8'h99; rd_req_valid = 1'b1;
    @(negedge clk); wr_valid = 1'b0; rd_req_valid = 1'b0;
    chk(!rd_rsp_valid, "R10 read yielded", int'(rd_rsp_valid), 0);
    // R10: index load beats a write
    @(negedge clk); idx_we = 1'b1; idx_din = 4'h5; wr_valid = 1'b1; wr_data = 8'h77;
    @(negedge clk); idx_we = 1'b0; wr_valid = 1'b0;
    chk(idx_q == 4'h5, "R10 load index", int'(idx_q), 5);
    do_rd(got);
    chk(got == 8'h01, "R10 write dropped", int'(got), 8'h01);
    do_idx(4'h2);
    do_rd(got);
    chk(got == 8'h55, "R10 shadow not committed lo", int'(got), 8'h55);
    do_rd(got);
    chk(got == 8'hAA, "R10 shadow not committed hi", int'(got), 8'hAA);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule